// File: doc/BRIEF.md
# Dual-Rate Timer with Timed Wake-Up

This block keeps two free-running time counters for a processor that schedules work at two priority levels. A prescaler turns the system clock into a one-microsecond tick. The fast counter advances on every tick. The slow counter advances once for every 64 ticks of the fast counter. A requester marks each request with its priority, and that priority selects which counter the request uses.

Through one request port, a requester can do one of two things. It can read the counter of its own priority, or it can park a wait that ends once that counter is strictly after a target value. Parked waits sit in a small table of slots, each tagged with a requester ID. When a slot's counter passes its target, the slot's ID comes out on a wake-up stream. A pending flag shows that at least one waiter is still parked. A cancel input removes a wait whose select was won by another input, and no wake-up is produced for it.

The request port and the wake-up port are valid/ready streams. A request transfers when `req_valid` and `req_ready` are both high on a rising edge. A read is always ready. A wait is ready only while a slot is free. On the wake-up port, `wake_valid` and `wake_id` stay stable until `wake_ready` is seen high. The one exception is a cancel that matches the presented ID, which withdraws it. The read response `rd_valid` is a one-cycle pulse with no back-pressure.

Top module: `dual_rate_after_timer`

## Requirements
- R1: The fast counter starts at 0 after reset and advances by exactly one every CYC_PER_US clock cycles. It wraps modulo 2^TW.
- R2: The slow counter starts at 0 and advances by one on every 64th advance of the fast counter, in the same cycle as that advance.
- R3: A read request (`req_wait`=0) that is accepted on a clock edge gives `rd_valid` high in the following cycle. `rd_time` then holds the value, just before that edge, of the slow counter if `req_low`=1 and of the fast counter if `req_low`=0.
- R4: A wait (`req_wait`=1) on counter C with target T is expired once (C − T), taken as a TW-bit two's-complement number, is greater than zero. Its ID is presented one cycle after the first cycle in which it is expired. This remains correct across counter wraparound.
- R5: A wait whose target has already passed when it is accepted is presented on `wake_valid` two cycles after acceptance.
- R6: Expired slots are released one per accepted transfer, lowest slot index first. A wait is stored in the lowest free slot. While `wake_ready` is low, `wake_valid` and `wake_id` hold their values.
- R7: A cancel pulse clears every parked wait that carries `cancel_id`, including one currently presented. No wake-up is emitted for it.
- R8: `pend_any` is high while any wait is parked or presented but not yet accepted, and low otherwise.
- R9: A wait request sees `req_ready` low while all SLOTS slots are occupied. A read request always sees `req_ready` high.
- R10: After reset, `rd_valid`, `wake_valid` and `pend_any` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_wait | input | 1 | 1 = park a wait, 0 = read a counter |
| req_low | input | 1 | Requester priority: 1 = slow counter, 0 = fast counter |
| req_time | input | TW | Target value for a wait |
| req_id | input | IDW | ID returned on wake-up |
| rd_valid | output | 1 | Read response pulse |
| rd_time | output | TW | Counter value for the read |
| cancel_valid | input | 1 | Cancel pulse |
| cancel_id | input | IDW | ID whose waits are removed |
| wake_valid | output | 1 | A wake-up is presented |
| wake_ready | input | 1 | Consumer accepts the wake-up |
| wake_id | output | IDW | ID of the released waiter |
| pend_any | output | 1 | At least one waiter not yet released |

## Verification
The hardest situation to reach is a fully occupied table whose entries all expire in the same cycle while the consumer holds back. That situation is needed to see release order, stall stability and refusal of a further wait together. The bench gets there by parking four waits with one shared target a few ticks ahead, in consecutive cycles, with `wake_ready` low. It then releases them one by one. Wraparound is reached by using an 8-bit counter and letting it run up to 250 before parking targets on both sides of the wrap point.

// File: rtl/dr_timer_pkg.sv
package dr_timer_pkg;
  typedef enum logic {PRI_FAST = 1'b0, PRI_SLOW = 1'b1} pri_e;
  typedef enum logic {OP_READ = 1'b0, OP_WAIT = 1'b1} op_e;
endpackage

// File: rtl/dr_timebase.sv
module dr_timebase #(
  parameter int CYC_PER_US = 100,
  parameter int SLOW_RATIO = 64,
  parameter int TW         = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] fast_cnt,
  output logic [TW-1:0] slow_cnt
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int DW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;

  logic [PW-1:0] pre_q;
  logic [DW-1:0] div_q;
  logic          us_tick, slow_tick;

  assign us_tick   = (pre_q == PW'(CYC_PER_US - 1));
  assign slow_tick = us_tick && (div_q == DW'(SLOW_RATIO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      div_q    <= '0;
      fast_cnt <= '0;
      slow_cnt <= '0;
    end else begin
      pre_q <= us_tick ? '0 : pre_q + PW'(1);
      if (us_tick) begin
        fast_cnt <= fast_cnt + TW'(1);
        div_q    <= slow_tick ? '0 : div_q + DW'(1);
      end
      if (slow_tick) slow_cnt <= slow_cnt + TW'(1);
    end
  end
endmodule

// File: rtl/dr_wait_table.sv
module dr_wait_table #(
  parameter int TW    = 32,
  parameter int SLOTS = 4,
  parameter int IDW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  fast_cnt,
  input  logic [TW-1:0]  slow_cnt,
  input  logic           alloc_valid,
  input  logic           alloc_low,
  input  logic [TW-1:0]  alloc_time,
  input  logic [IDW-1:0] alloc_id,
  output logic           has_free,
  input  logic           cancel_valid,
  input  logic [IDW-1:0] cancel_id,
  output logic           wake_valid,
  input  logic           wake_ready,
  output logic [IDW-1:0] wake_id,
  output logic           pend_any
);
  logic [SLOTS-1:0] used_q, low_q, expired, killed, eligible;
  logic [SLOTS-1:0] free_oh, pick_oh;
  logic [TW-1:0]    tgt_q [SLOTS];
  logic [IDW-1:0]   id_q  [SLOTS];
  logic             out_v_q, out_kill, load_en;
  logic [IDW-1:0]   out_id_q, pick_id;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [TW-1:0] delta;
    assign delta      = (low_q[i] ? slow_cnt : fast_cnt) - tgt_q[i];
    assign expired[i] = used_q[i] && !delta[TW-1] && (delta != '0);
    assign killed[i]  = cancel_valid && used_q[i] && (id_q[i] == cancel_id);
  end

  assign eligible = expired & ~killed;

  always_comb begin
    free_oh = '0;
    pick_oh = '0;
    pick_id = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!used_q[i]) free_oh = SLOTS'(1) << i;
      if (eligible[i]) begin
        pick_oh = SLOTS'(1) << i;
        pick_id = id_q[i];
      end
    end
  end

  assign has_free = |free_oh;
  assign out_kill = cancel_valid && out_v_q && (out_id_q == cancel_id);
  assign load_en  = !out_v_q || wake_ready || out_kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q   <= '0;
      low_q    <= '0;
      out_v_q  <= 1'b0;
      out_id_q <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        tgt_q[i] <= '0;
        id_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (killed[i] || (load_en && pick_oh[i])) used_q[i] <= 1'b0;
        if (alloc_valid && free_oh[i]) begin
          used_q[i] <= 1'b1;
          low_q[i]  <= alloc_low;
          tgt_q[i]  <= alloc_time;
          id_q[i]   <= alloc_id;
        end
      end
      if (load_en) begin
        out_v_q  <= |eligible;
        out_id_q <= pick_id;
      end
    end
  end

  assign wake_valid = out_v_q;
  assign wake_id    = out_id_q;
  assign pend_any   = (|used_q) || out_v_q;
endmodule

// File: rtl/dual_rate_after_timer.sv
module dual_rate_after_timer
  import dr_timer_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int SLOW_RATIO = 64,
  parameter int TW         = 32,
  parameter int SLOTS      = 4,
  parameter int IDW        = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_wait,
  input  logic           req_low,
  input  logic [TW-1:0]  req_time,
  input  logic [IDW-1:0] req_id,
  output logic           rd_valid,
  output logic [TW-1:0]  rd_time,
  input  logic           cancel_valid,
  input  logic [IDW-1:0] cancel_id,
  output logic           wake_valid,
  input  logic           wake_ready,
  output logic [IDW-1:0] wake_id,
  output logic           pend_any
);
  logic [TW-1:0] fast_now, slow_now;
  logic          slot_free, do_wait, do_read;

  dr_timebase #(.CYC_PER_US(CYC_PER_US), .SLOW_RATIO(SLOW_RATIO), .TW(TW)) u_base (
    .clk(clk), .rst_n(rst_n), .fast_cnt(fast_now), .slow_cnt(slow_now)
  );

  assign req_ready = (op_e'(req_wait) == OP_READ) || slot_free;
  assign do_wait   = req_valid && (op_e'(req_wait) == OP_WAIT) && slot_free;
  assign do_read   = req_valid && (op_e'(req_wait) == OP_READ);

  dr_wait_table #(.TW(TW), .SLOTS(SLOTS), .IDW(IDW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .fast_cnt(fast_now), .slow_cnt(slow_now),
    .alloc_valid(do_wait), .alloc_low(req_low), .alloc_time(req_time),
    .alloc_id(req_id), .has_free(slot_free),
    .cancel_valid(cancel_valid), .cancel_id(cancel_id),
    .wake_valid(wake_valid), .wake_ready(wake_ready), .wake_id(wake_id),
    .pend_any(pend_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_time  <= '0;
    end else begin
      rd_valid <= do_read;
      if (do_read) rd_time <= (pri_e'(req_low) == PRI_SLOW) ? slow_now : fast_now;
    end
  end
endmodule

// File: rtl/dr_timer_chk.sv
module dr_timer_chk #(
  parameter int TW  = 32,
  parameter int IDW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [TW-1:0]  fast_now,
  input logic [TW-1:0]  slow_now,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_wait,
  input logic           rd_valid,
  input logic           cancel_valid,
  input logic [IDW-1:0] cancel_id,
  input logic           wake_valid,
  input logic           wake_ready,
  input logic [IDW-1:0] wake_id
);
  assert_fast_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fast_now == $past(fast_now)) || (fast_now == $past(fast_now) + TW'(1)));

  assert_slow_with_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_now != $past(slow_now)) |-> (fast_now != $past(fast_now)));

  assert_read_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && req_ready && !req_wait));

  assert_wake_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && !wake_ready && !(cancel_valid && cancel_id == wake_id))
      |=> (wake_valid && $stable(wake_id)));

  assert_cancel_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_valid && wake_valid && cancel_id == wake_id)
      |=> !(wake_valid && wake_id == $past(cancel_id)));

  assert_read_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wait) |-> req_ready);
endmodule

bind dual_rate_after_timer dr_timer_chk #(.TW(TW), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fast_now(fast_now), .slow_now(slow_now),
  .req_valid(req_valid), .req_ready(req_ready), .req_wait(req_wait),
  .rd_valid(rd_valid), .cancel_valid(cancel_valid), .cancel_id(cancel_id),
  .wake_valid(wake_valid), .wake_ready(wake_ready), .wake_id(wake_id)
);

// File: tb/dual_rate_after_timer_tb.sv
module dual_rate_after_timer_tb;
  localparam int C = 2, TW = 8, SLOTS = 4, IDW = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wait = 0, req_low = 0;
  logic [TW-1:0] req_time = '0;
  logic [IDW-1:0] req_id = '0, cancel_id = '0;
  logic cancel_valid = 0, wake_ready = 1;
  logic req_ready, rd_valid, wake_valid, pend_any;
  logic [TW-1:0] rd_time;
  logic [IDW-1:0] wake_id;

  int checks = 0, errors = 0, ecount = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) ecount <= ecount + 1;

  dual_rate_after_timer #(.CYC_PER_US(C), .SLOW_RATIO(64), .TW(TW), .SLOTS(SLOTS), .IDW(IDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wait(req_wait), .req_low(req_low), .req_time(req_time), .req_id(req_id),
    .rd_valid(rd_valid), .rd_time(rd_time), .cancel_valid(cancel_valid),
    .cancel_id(cancel_id), .wake_valid(wake_valid), .wake_ready(wake_ready),
    .wake_id(wake_id), .pend_any(pend_any));

  function automatic int fast_at(int e); return (e / C) % 256; endfunction
  function automatic int slow_at(int e); return (e / (C * 64)) % 256; endfunction
  function automatic bit after8(int t, int tgt);
    logic [7:0] d;
    d = 8'(t - tgt);
    return !d[7] && d != 0;
  endfunction
  function automatic int wake_edge(bit low, int tgt, int eacc);
    int n;
    n = eacc + 1;
    while (!after8(low ? slow_at(n) : fast_at(n), tgt)) n++;
    return n + 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_read(bit low, string tag);
    int exp;
    req_valid = 1; req_wait = 0; req_low = low;
    exp = low ? slow_at(ecount) : fast_at(ecount);
    @(negedge clk);
    req_valid = 0;
    check(rd_valid && rd_time == TW'(exp), tag, rd_time, exp);
  endtask

  task automatic park(bit low, int tgt, int id, output int eacc);
    req_valid = 1; req_wait = 1; req_low = low; req_time = TW'(tgt); req_id = IDW'(id);
    check(req_ready, "R9 wait ready with free slot", req_ready, 1);
    eacc = ecount;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_wake(int id, int w, string tag);
    int guard = 0;
    while (!wake_valid && guard < 40000) begin @(negedge clk); guard++; end
    check(ecount == w, tag, ecount, w);
    check(wake_id == IDW'(id), tag, wake_id, id);
    @(negedge clk);
  endtask

  task automatic wait_case(bit low, int tgt, int id, string tag);
    int eacc;
    park(low, tgt, id, eacc);
    check(pend_any, "R8 pending after park", pend_any, 1);
    expect_wake(id, wake_edge(low, tgt, eacc), tag);
  endtask

  initial begin
    int eacc, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!rd_valid && !wake_valid && !pend_any, "R10 reset outputs", {rd_valid, wake_valid, pend_any}, 0);
    do_read(0, "R10 fast counter zero after reset");

    for (int i = 0; i < 40; i++) begin
      repeat ((i * 13) % 50) @(negedge clk);
      do_read(i[0], i[0] ? "R2 slow counter read" : "R1 fast counter read");
    end

    for (int d = -4; d <= 6; d++)
      wait_case(0, fast_at(ecount) + d, d & 7, d <= 0 ? "R5 passed target wake" : "R4 fast wait wake");
    wait_case(1, slow_at(ecount), 2, "R4 slow wait wake");
    wait_case(1, slow_at(ecount) + 1, 3, "R4 slow wait future");

    while (fast_at(ecount) != 250) @(negedge clk);
    wait_case(0, 2, 1, "R4 wrap target beyond zero");
    while (fast_at(ecount) != 250) @(negedge clk);
    wait_case(0, 254, 6, "R4 target just before wrap");

    wake_ready = 0;
    begin
      int tgt = fast_at(ecount) + 4;
      int ids[4] = '{5, 6, 7, 1};
      int firstacc = 0;
      for (int k = 0; k < 4; k++) begin park(0, tgt, ids[k], eacc); if (k == 0) firstacc = eacc; end
      req_valid = 1; req_wait = 1; #1;
      check(!req_ready, "R9 wait refused when full", req_ready, 0);
      req_wait = 0; #1;
      check(req_ready, "R9 read ready when full", req_ready, 1);
      req_valid = 0;
      while (!wake_valid) @(negedge clk);
      check(ecount == wake_edge(0, tgt, firstacc), "R4 shared target expiry", ecount, wake_edge(0, tgt, firstacc));
      for (int k = 0; k < 3; k++) begin
        check(wake_valid && wake_id == 3'd5, "R6 hold under back-pressure", wake_id, 5);
        @(negedge clk);
      end
      wake_ready = 1;
      for (int k = 0; k < 4; k++) begin
        check(wake_valid && wake_id == IDW'(ids[k]), "R6 lowest slot first", wake_id, ids[k]);
        @(negedge clk);
      end
      check(!wake_valid && !pend_any, "R8 idle after drain", {wake_valid, pend_any}, 0);
    end

    park(0, fast_at(ecount) + 20, 3, eacc);
    repeat (3) @(negedge clk);
    cancel_valid = 1; cancel_id = 3;
    @(negedge clk);
    cancel_valid = 0;
    check(!pend_any, "R7 cancel clears parked wait", pend_any, 0);
    bad = 0;
    repeat (80) begin @(negedge clk); if (wake_valid) bad++; end
    check(bad == 0, "R7 no wake after cancel", bad, 0);

    wake_ready = 0;
    park(0, fast_at(ecount) - 3, 4, eacc);
    while (!wake_valid) @(negedge clk);
    cancel_valid = 1; cancel_id = 4;
    @(negedge clk);
    cancel_valid = 0;
    check(!wake_valid && !pend_any, "R7 cancel withdraws presented wake", wake_valid, 0);
    wake_ready = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule